// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings the supply rails and control signals of an LCD timing generator up and down in a fixed order. It does this by issuing 8-bit writes to numbered control registers through a one-cycle write strobe. It inserts millisecond pauses between groups of writes. Twice in the flow it hands a bias code to an external serial DAC writer and waits for that writer to finish.

A power-up request on a panel that has never been brought up, or that has been powered down since, runs the full rail sequence. The sequence finishes by writing the phase, polarity and resolution registers. A power-up request on a panel that is already running only rewrites the phase and resolution registers, which is how a mode change is applied. A power-down request waits two frame times and then removes the rails in reverse order.

The mode select, the stored phase and the stored bias, together with their valid flags, are captured on the cycle a power-up request is accepted. Millisecond timing comes from a parameter that gives the number of clock cycles per millisecond.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, `busy`, `reg_wr` and `dac_start` are low and the panel counts as not initialized, so the first power-up request runs the full sequence.
- R2: A full power-up writes, in this order (register address = value, hex): 6=1F, 3=03, 4=00, 4=04, [3 ms], 3=07, 6=09, [DAC step], 3=17, 4=06, [2 ms], 6=01, 3=1F, 4=07, 6=00, 1=phase, 7=00, [1 ms], 0=resolution.
- R3: A DAC step raises `dac_start` for exactly one cycle, with `dac_base` and `dac_value` valid in that cycle. No further write happens until `dac_done` is seen. In power-up the base is 0x04 and the value is the captured bias, or 125 (0x7D) when the bias valid flag is low.
- R4: The phase byte is `((phase_val & 0xF) << 1) | 1` in VGA mode (`vga_sel`=1) with a valid phase, 0x01 in VGA mode without one, and 0x13 in QVGA mode (`vga_sel`=0) whatever the phase inputs are.
- R5: The last write of every power-up goes to register 0 and carries 0x00 for VGA or 0x01 for QVGA.
- R6: A power-up request on an initialized panel produces exactly two writes: register 1 = phase byte, then register 0 = resolution byte.
- R7: A power-down writes 4=06, 6=08, 3=14, [DAC step with base 0x14 and value 0x00], 4=04, 3=04, 6=1E, 3=00, 4=00. It then marks the panel not initialized, so the next power-up is a full one.
- R8: A pause of N ms places the next write exactly N*CYCLES_PER_MS+2 cycles after the previous write. For the 34 ms pause that opens power-down, the first write comes 34*CYCLES_PER_MS+2 cycles after the clock edge that accepted the request.
- R9: `busy` goes high at the clock edge that accepts a request and falls one cycle after the last write of the sequence. `reg_wr` is never high while `busy` is low.
- R10: Power-up or power-down requests that arrive while `busy` is high have no effect on the running sequence and are not queued.
- R11: If both requests are high in the same idle cycle, power-down wins. A power-down on a panel that is not initialized still runs the full power-down.
- R12: Consecutive writes go out on consecutive cycles as single-cycle strobes. The first write of a power-up comes one cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_on_req | input | 1 | Power-up / reconfigure request (sampled when idle) |
| pwr_off_req | input | 1 | Power-down request (sampled when idle) |
| vga_sel | input | 1 | 1 = VGA, 0 = QVGA |
| phase_valid | input | 1 | Stored phase value is valid |
| phase_val | input | 8 | Stored phase value (low 4 bits used) |
| bias_valid | input | 1 | Stored bias value is valid |
| bias_val | input | 8 | Stored bias code |
| busy | output | 1 | A sequence is in progress |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 3 | Register address |
| reg_data | output | 8 | Register data |
| dac_start | output | 1 | Start pulse to the serial DAC writer |
| dac_base | output | 8 | Base control byte for the DAC writer |
| dac_value | output | 8 | Bias code to program |
| dac_done | input | 1 | DAC writer finished |

## Verification
Register writes are due one cycle after the step that issues them. Writes inside a group therefore sit on consecutive cycles, and a write following an N ms pause arrives N*CYCLES_PER_MS+2 cycles after the write before it. The bench timestamps every write and DAC start by cycle count, taking samples on the falling edge. It compares each gap against these exact figures, and also the offset from the accepting edge: 1 cycle for power-up and 34*CYCLES_PER_MS+2 cycles for power-down. The falling edge of `busy` is checked to come exactly one cycle after the final write. The bench's DAC model answers a fixed number of cycles after each start pulse, so the sequence has to hold until `dac_done` arrives.

// File: rtl/lcd_pwr_pkg.sv
// Shared definitions for the LCD power sequencer: register numbers,
// program entry points and the step descriptor.
// Assumes an 8-entry register space and 8-bit register data.
package lcd_pwr_pkg;

    localparam int REG_AW = 3;
    localparam int DW     = 8;
    localparam int PC_W   = 6;

    localparam logic [REG_AW-1:0] RA_RES   = 3'd0;
    localparam logic [REG_AW-1:0] RA_PHASE = 3'd1;
    localparam logic [REG_AW-1:0] RA_PWR0  = 3'd3;
    localparam logic [REG_AW-1:0] RA_PWR1  = 3'd4;
    localparam logic [REG_AW-1:0] RA_PANEL = 3'd6;
    localparam logic [REG_AW-1:0] RA_POL   = 3'd7;

    localparam logic [PC_W-1:0] PC_UP    = 6'd0;
    localparam logic [PC_W-1:0] PC_RECFG = 6'd20;
    localparam logic [PC_W-1:0] PC_DOWN  = 6'd23;

    typedef enum logic [2:0] {
        K_WR     = 3'd0,
        K_WAIT   = 3'd1,
        K_DAC    = 3'd2,
        K_END_UP = 3'd3,
        K_END_DN = 3'd4
    } step_kind_e;

    typedef struct packed {
        step_kind_e       kind;
        logic [REG_AW-1:0] addr;
        logic [DW-1:0]     data;   // write data, or DAC value
        logic [DW-1:0]     aux;    // pause length in ms, or DAC base
    } step_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_MS   = 2'd2,
        S_DAC  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/lcd_pwr_prog.sv
// Step program of the sequencer: maps a program counter to one step.
// Three programs share the space: full power-up from PC_UP, phase and
// resolution reconfiguration from PC_RECFG, power-down from PC_DOWN.
// Assumes the captured phase, resolution and bias bytes are stable while
// a program runs.
module lcd_pwr_prog
    import lcd_pwr_pkg::*;
(
    input  logic [PC_W-1:0] pc,
    input  logic [DW-1:0]   phase_byte,
    input  logic [DW-1:0]   res_byte,
    input  logic [DW-1:0]   bias_byte,
    output step_t           step
);

    function automatic step_t wr(input logic [REG_AW-1:0] a, input logic [DW-1:0] d);
        wr = '{kind: K_WR, addr: a, data: d, aux: '0};
    endfunction

    function automatic step_t pause(input logic [DW-1:0] ms);
        pause = '{kind: K_WAIT, addr: '0, data: '0, aux: ms};
    endfunction

    function automatic step_t dac(input logic [DW-1:0] base, input logic [DW-1:0] v);
        dac = '{kind: K_DAC, addr: '0, data: v, aux: base};
    endfunction

    // Decode the step selected by the program counter
    always_comb begin
        case (pc)
            6'd0:  step = wr(RA_PANEL, 8'h1F);
            6'd1:  step = wr(RA_PWR0,  8'h03);
            6'd2:  step = wr(RA_PWR1,  8'h00);
            6'd3:  step = wr(RA_PWR1,  8'h04);
            6'd4:  step = pause(8'd3);
            6'd5:  step = wr(RA_PWR0,  8'h07);
            6'd6:  step = wr(RA_PANEL, 8'h09);
            6'd7:  step = dac(8'h04, bias_byte);
            6'd8:  step = wr(RA_PWR0,  8'h17);
            6'd9:  step = wr(RA_PWR1,  8'h06);
            6'd10: step = pause(8'd2);
            6'd11: step = wr(RA_PANEL, 8'h01);
            6'd12: step = wr(RA_PWR0,  8'h1F);
            6'd13: step = wr(RA_PWR1,  8'h07);
            6'd14: step = wr(RA_PANEL, 8'h00);
            6'd15: step = wr(RA_PHASE, phase_byte);
            6'd16: step = wr(RA_POL,   8'h00);
            6'd17: step = pause(8'd1);
            6'd18: step = wr(RA_RES,   res_byte);
            6'd19: step = '{kind: K_END_UP, addr: '0, data: '0, aux: '0};
            6'd20: step = wr(RA_PHASE, phase_byte);
            6'd21: step = wr(RA_RES,   res_byte);
            6'd22: step = '{kind: K_END_UP, addr: '0, data: '0, aux: '0};
            6'd23: step = pause(8'd34);
            6'd24: step = wr(RA_PWR1,  8'h06);
            6'd25: step = wr(RA_PANEL, 8'h08);
            6'd26: step = wr(RA_PWR0,  8'h14);
            6'd27: step = dac(8'h14, 8'h00);
            6'd28: step = wr(RA_PWR1,  8'h04);
            6'd29: step = wr(RA_PWR0,  8'h04);
            6'd30: step = wr(RA_PANEL, 8'h1E);
            6'd31: step = wr(RA_PWR0,  8'h00);
            6'd32: step = wr(RA_PWR1,  8'h00);
            default: step = '{kind: K_END_DN, addr: '0, data: '0, aux: '0};
        endcase
    end

endmodule

// File: rtl/lcd_pwr_mstimer.sv
// Millisecond pause timer. A start pulse loads a pause length in ms;
// expire is high in the last cycle of the pause, N*CYCLES_PER_MS cycles
// after the loading edge. Assumes a nonzero pause length.
module lcd_pwr_mstimer #(
    parameter int CYCLES_PER_MS = 250000,
    parameter int MS_W          = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [MS_W-1:0] ms_len,
    output logic            expire
);

    localparam int PRE_W = (CYCLES_PER_MS > 1) ? $clog2(CYCLES_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_RELOAD = PRE_W'(CYCLES_PER_MS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;
    logic             active_q;

    assign expire = active_q && (pre_q == '0) && (ms_q == MS_W'(1));

    // Count the prescaler down and step the millisecond counter on wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q    <= '0;
            ms_q     <= '0;
            active_q <= 1'b0;
        end else if (start) begin
            pre_q    <= PRE_RELOAD;
            ms_q     <= ms_len;
            active_q <= 1'b1;
        end else if (active_q) begin
            if (pre_q == '0) begin
                pre_q <= PRE_RELOAD;
                ms_q  <= ms_q - 1'b1;
                if (ms_q == MS_W'(1)) active_q <= 1'b0;
            end else begin
                pre_q <= pre_q - 1'b1;
            end
        end
    end

    // R8
    ms_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (ms_q != '0));

    // R8
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !start && pre_q == '0 && ms_q != MS_W'(1)) |=> (pre_q == PRE_RELOAD));

endmodule

// File: rtl/lcd_pwr_seq.sv
// LCD panel power sequencer top. When idle it accepts a power-up or
// power-down request (power-down wins), captures mode, phase and bias,
// and walks the step program: one register write per cycle, millisecond
// pauses through the timer, and DAC steps held until dac_done.
// Assumes the DAC writer raises dac_done only after a dac_start.
module lcd_pwr_seq
    import lcd_pwr_pkg::*;
#(
    parameter int CYCLES_PER_MS = 250000,
    parameter int DEFAULT_BIAS  = 125,
    parameter int QVGA_PHASE    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on_req,
    input  logic              pwr_off_req,
    input  logic              vga_sel,
    input  logic              phase_valid,
    input  logic [DW-1:0]     phase_val,
    input  logic              bias_valid,
    input  logic [DW-1:0]     bias_val,
    output logic              busy,
    output logic              reg_wr,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DW-1:0]     reg_data,
    output logic              dac_start,
    output logic [DW-1:0]     dac_base,
    output logic [DW-1:0]     dac_value,
    input  logic              dac_done
);

    localparam logic [DW-1:0] BIAS_DFLT  = DW'(DEFAULT_BIAS);
    localparam logic [DW-1:0] QVGA_PBYTE = DW'(((QVGA_PHASE % 16) * 2) + 1);

    seq_state_e      state_q;
    logic [PC_W-1:0] pc_q;
    logic            inited_q;
    logic [DW-1:0]   phase_q, res_q, bias_q;
    logic [DW-1:0]   phase_nx, res_nx, bias_nx;
    step_t           step;
    logic            ms_start, ms_expire;

    // Derive the bytes to capture from the request-time inputs
    always_comb begin
        if (!vga_sel)         phase_nx = QVGA_PBYTE;
        else if (phase_valid) phase_nx = {3'b000, phase_val[3:0], 1'b1};
        else                  phase_nx = 8'h01;
        res_nx  = vga_sel ? 8'h00 : 8'h01;
        bias_nx = bias_valid ? bias_val : BIAS_DFLT;
    end

    lcd_pwr_prog u_prog (
        .pc         (pc_q),
        .phase_byte (phase_q),
        .res_byte   (res_q),
        .bias_byte  (bias_q),
        .step       (step)
    );

    assign ms_start = (state_q == S_RUN) && (step.kind == K_WAIT);

    lcd_pwr_mstimer #(
        .CYCLES_PER_MS (CYCLES_PER_MS),
        .MS_W          (DW)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (ms_start),
        .ms_len (step.aux),
        .expire (ms_expire)
    );

    assign busy = (state_q != S_IDLE);

    // Sequence control: accept requests, execute steps, drive outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            pc_q      <= '0;
            inited_q  <= 1'b0;
            phase_q   <= '0;
            res_q     <= '0;
            bias_q    <= '0;
            reg_wr    <= 1'b0;
            reg_addr  <= '0;
            reg_data  <= '0;
            dac_start <= 1'b0;
            dac_base  <= '0;
            dac_value <= '0;
        end else begin
            reg_wr    <= 1'b0;
            dac_start <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (pwr_off_req) begin
                        state_q <= S_RUN;
                        pc_q    <= PC_DOWN;
                    end else if (pwr_on_req) begin
                        state_q <= S_RUN;
                        pc_q    <= inited_q ? PC_RECFG : PC_UP;
                        phase_q <= phase_nx;
                        res_q   <= res_nx;
                        bias_q  <= bias_nx;
                    end
                end
                S_RUN: begin
                    case (step.kind)
                        K_WR: begin
                            reg_wr   <= 1'b1;
                            reg_addr <= step.addr;
                            reg_data <= step.data;
                            pc_q     <= pc_q + 1'b1;
                        end
                        K_WAIT: state_q <= S_MS;
                        K_DAC: begin
                            dac_start <= 1'b1;
                            dac_base  <= step.aux;
                            dac_value <= step.data;
                            state_q   <= S_DAC;
                        end
                        K_END_UP: begin
                            inited_q <= 1'b1;
                            state_q  <= S_IDLE;
                        end
                        default: begin
                            inited_q <= 1'b0;
                            state_q  <= S_IDLE;
                        end
                    endcase
                end
                S_MS: begin
                    if (ms_expire) begin
                        pc_q    <= pc_q + 1'b1;
                        state_q <= S_RUN;
                    end
                end
                default: begin
                    if (dac_done) begin
                        pc_q    <= pc_q + 1'b1;
                        state_q <= S_RUN;
                    end
                end
            endcase
        end
    end

    // R9
    wr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> busy);

    // R3
    dac_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_start |=> !dac_start);

    // R3
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DAC && !dac_done) |=> !reg_wr);

    // R10
    start_by_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(pwr_on_req || pwr_off_req));

    // R11
    off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pwr_off_req) |=> (busy && pc_q == PC_DOWN));

endmodule

// File: tb/lcd_pwr_seq_bench.sv
module lcd_pwr_seq_bench;

    localparam int CPM     = 20;
    localparam int DAC_DLY = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_on_req = 1'b0, pwr_off_req = 1'b0;
    logic       vga_sel = 1'b0, phase_valid = 1'b0, bias_valid = 1'b0;
    logic [7:0] phase_val = '0, bias_val = '0;
    logic       busy, reg_wr, dac_start;
    logic       dac_done = 1'b0;
    logic [2:0] reg_addr;
    logic [7:0] reg_data, dac_base, dac_value;

    always #2 clk = ~clk;

    lcd_pwr_seq #(.CYCLES_PER_MS(CPM)) u_lcd_pwr_seq (
        .clk(clk), .rst_n(rst_n),
        .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
        .vga_sel(vga_sel), .phase_valid(phase_valid), .phase_val(phase_val),
        .bias_valid(bias_valid), .bias_val(bias_val),
        .busy(busy), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data),
        .dac_start(dac_start), .dac_base(dac_base), .dac_value(dac_value),
        .dac_done(dac_done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tests = 0, fails = 0;
    bit finished = 0;

    logic [16:0] ev [0:63];
    int          ev_t [0:63];
    int          ev_n = 0;
    int          busy_rise = -1, busy_fall = -1;
    logic [16:0] exq [0:63];
    int          exn = 0;
    int          req_edge = 0;

    // event monitor on the falling edge
    initial begin
        logic prev_busy;
        prev_busy = 1'b0;
        forever begin
            @(negedge clk);
            if (reg_wr && ev_n < 64) begin
                ev[ev_n] = {1'b0, 5'b0, reg_addr, reg_data}; ev_t[ev_n] = cyc; ev_n++;
            end
            if (dac_start && ev_n < 64) begin
                ev[ev_n] = {1'b1, dac_base, dac_value}; ev_t[ev_n] = cyc; ev_n++;
            end
            if (busy && !prev_busy) busy_rise = cyc;
            if (!busy && prev_busy) busy_fall = cyc;
            prev_busy = busy;
        end
    end

    // DAC writer model
    initial begin
        forever begin
            @(negedge clk);
            if (dac_start) begin
                repeat (DAC_DLY) @(negedge clk);
                dac_done = 1'b1;
                @(negedge clk);
                dac_done = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic ew(input int a, input int d);
        exq[exn] = {1'b0, 8'(a), 8'(d)}; exn++;
    endtask

    task automatic ed(input int b, input int v);
        exq[exn] = {1'b1, 8'(b), 8'(v)}; exn++;
    endtask

    function automatic int phase_exp(input bit vga, input bit pv, input int p);
        if (!vga) return 9 * 2 + 1;
        if (!pv)  return 1;
        return (p % 16) * 2 + 1;
    endfunction

    task automatic build_up(input bit vga, input bit pv, input int p, input bit bv, input int b);
        exn = 0;
        ew(6,'h1F); ew(3,'h03); ew(4,'h00); ew(4,'h04); ew(3,'h07); ew(6,'h09);
        ed('h04, bv ? b : 125);
        ew(3,'h17); ew(4,'h06); ew(6,'h01); ew(3,'h1F); ew(4,'h07); ew(6,'h00);
        ew(1, phase_exp(vga, pv, p)); ew(7,'h00); ew(0, vga ? 0 : 1);
    endtask

    task automatic build_recfg(input bit vga, input bit pv, input int p);
        exn = 0;
        ew(1, phase_exp(vga, pv, p)); ew(0, vga ? 0 : 1);
    endtask

    task automatic build_down();
        exn = 0;
        ew(4,'h06); ew(6,'h08); ew(3,'h14); ed('h14, 0);
        ew(4,'h04); ew(3,'h04); ew(6,'h1E); ew(3,'h00); ew(4,'h00);
    endtask

    task automatic do_req(input bit on, input bit off);
        @(negedge clk);
        ev_n = 0; busy_rise = -1; busy_fall = -1;
        pwr_on_req = on; pwr_off_req = off;
        req_edge = cyc + 1;
        @(negedge clk);
        pwr_on_req = 1'b0; pwr_off_req = 1'b0;
    endtask

    task automatic inject(input int after, input bit on, input bit off);
        repeat (after) @(negedge clk);
        pwr_on_req = on; pwr_off_req = off;
        @(negedge clk);
        pwr_on_req = 1'b0; pwr_off_req = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int guard;
        guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 5000, tag, guard, 5000);
        repeat (2) @(negedge clk);
    endtask

    task automatic compare(input string tag);
        chk(ev_n == exn, tag, ev_n, exn);
        for (int i = 0; i < exn && i < ev_n; i++)
            chk(ev[i] == exq[i], tag, int'(ev[i]), int'(exq[i]));
        chk(busy_rise == req_edge, "R9 busy rise", busy_rise, req_edge);
        if (ev_n > 0)
            chk(busy_fall == ev_t[ev_n-1] + 1, "R9 busy fall", busy_fall, ev_t[ev_n-1] + 1);
    endtask

    task automatic up_timing();
        if (ev_n == 16) begin
            chk(ev_t[0] - req_edge == 1, "R12 first write", ev_t[0] - req_edge, 1);
            chk(ev_t[1] - ev_t[0] == 1, "R12 back-to-back", ev_t[1] - ev_t[0], 1);
            chk(ev_t[4] - ev_t[3] == 3*CPM+2, "R8 3ms", ev_t[4] - ev_t[3], 3*CPM+2);
            chk(ev_t[9] - ev_t[8] == 2*CPM+2, "R8 2ms", ev_t[9] - ev_t[8], 2*CPM+2);
            chk(ev_t[15] - ev_t[14] == CPM+2, "R8 1ms", ev_t[15] - ev_t[14], CPM+2);
            chk(ev_t[7] - ev_t[6] > DAC_DLY, "R3 hold until done", ev_t[7] - ev_t[6], DAC_DLY+1);
        end
    endtask

    task automatic down_timing();
        if (ev_n == 9) begin
            chk(ev_t[0] - req_edge == 34*CPM+2, "R8 34ms", ev_t[0] - req_edge, 34*CPM+2);
            chk(ev_t[4] - ev_t[3] > DAC_DLY, "R3 hold until done", ev_t[4] - ev_t[3], DAC_DLY+1);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!busy && !reg_wr && !dac_start, "R1 in reset", {busy, reg_wr, dac_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !reg_wr && !dac_start, "R1 after reset", {busy, reg_wr, dac_start}, 0);

        // R11: both requests at once on an uninitialized panel -> power-down
        do_req(1'b1, 1'b1);
        wait_idle("R11 idle");
        build_down(); compare("R11 off priority"); down_timing();

        // R1/R2: first power-up is full; VGA, no stored phase or bias; R10 off mid-run
        vga_sel = 1'b1; phase_valid = 1'b0; bias_valid = 1'b0;
        do_req(1'b1, 1'b0);
        inject(30, 1'b0, 1'b1);
        wait_idle("R2 idle");
        build_up(1'b1, 1'b0, 0, 1'b0, 0); compare("R2 full up"); up_timing();

        // R6/R4/R5: reconfiguration sweep
        for (int m = 0; m < 2; m++)
            for (int v = 0; v < 2; v++)
                for (int p = 0; p < 16; p++) begin
                    vga_sel = m[0]; phase_valid = v[0];
                    phase_val = {4'(p * 3 + 1), 4'(p)};
                    bias_valid = 1'b1; bias_val = 8'(p);
                    do_req(1'b1, 1'b0);
                    vga_sel = ~vga_sel; phase_val = ~phase_val;
                    wait_idle("R6 idle");
                    build_recfg(m[0], v[0], p); compare("R6 R4 R5 reconfig");
                    if (ev_n == 2)
                        chk(ev_t[0] - req_edge == 1 && ev_t[1] - ev_t[0] == 1,
                            "R12 reconfig timing", ev_t[1] - req_edge, 2);
                end

        // R7/R10: power-down with a stray power-up request in the pause
        do_req(1'b0, 1'b1);
        inject(50, 1'b1, 1'b0);
        wait_idle("R7 idle");
        build_down(); compare("R7 R10 power-down"); down_timing();

        // R7/R4/R3: full up again (flag cleared), QVGA ignores stored phase, explicit bias
        vga_sel = 1'b0; phase_valid = 1'b1; phase_val = 8'h05; bias_valid = 1'b1; bias_val = 8'd200;
        do_req(1'b1, 1'b0);
        wait_idle("R7 up idle");
        build_up(1'b0, 1'b1, 5, 1'b1, 200); compare("R7 R4 full up qvga"); up_timing();

        // R4/R3: VGA with masked stored phase and bias 0
        do_req(1'b0, 1'b1);
        wait_idle("R7 idle2");
        build_down(); compare("R7 power-down 2");
        vga_sel = 1'b1; phase_valid = 1'b1; phase_val = 8'hFA; bias_valid = 1'b1; bias_val = 8'h00;
        do_req(1'b1, 1'b0);
        wait_idle("R4 idle");
        build_up(1'b1, 1'b1, 'hA, 1'b1, 0); compare("R4 R3 full up vga"); up_timing();

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule